// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is the first interval timer of a peripheral interface adapter. It holds a 16-bit down-counter and a 16-bit reload latch, both reached through four byte-wide register selections. The counter moves down by one on every cycle in which the tick enable is high. When it steps from zero it reports an expiry to the neighbouring interrupt-flag logic. One tick later it reloads from the latch, so one full cycle of the counter lasts the latch value plus two ticks.

Bit 6 of the auxiliary control byte chooses between two modes. In free-running mode every pass through zero is reported. In one-shot mode only the first pass after a counter load is reported. Some register accesses also send a one-cycle clear request to the interrupt-flag logic. Both outgoing pulses are registered, so each one appears in the cycle after the clock edge that causes it.

Top module: `reload_timer`

## Requirements
- R1: After reset, reads of all four selections return 0xFF (latch and counter both 0xFFFF), and `expire_o` and `flag_clr_o` are low.
- R2: `rd_data_o` depends on `sel_i` combinationally: 0 gives the counter low byte, 1 the counter high byte, 2 the latch low byte and 3 the latch high byte.
- R3: A write with `sel_i` equal to 0 or 2 replaces only the latch low byte. The counter is left unchanged.
- R4: A write with `sel_i` = 1 stores the latch high byte and copies the whole new latch into the counter on the same edge. A one-cycle `flag_clr_o` pulse follows.
- R5: A write with `sel_i` = 3 stores the latch high byte and produces a `flag_clr_o` pulse. It does not load the counter.
- R6: A read with `sel_i` = 0 produces a `flag_clr_o` pulse in the next cycle. A read with `sel_i` = 1, 2 or 3 does not.
- R7: The counter changes only on edges where `tick_en_i` is high, or where a write with `sel_i` = 1 occurs.
- R8: On a tick, a counter at zero becomes 0xFFFF. The next tick reloads it from the latch, which makes the period the latch value plus two ticks.
- R9: When `ctrl_i[6]` = 1 (free-running), every tick that takes the counter from zero to 0xFFFF raises `expire_o` for exactly one cycle, in the cycle that follows.
- R10: When `ctrl_i[6]` = 0 (one-shot), only the first pass through zero after a write with `sel_i` = 1 raises `expire_o`. The counter keeps counting and reloading.
- R11: If a tick and a write with `sel_i` = 1 land on the same edge, the load takes effect and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Count enable, one decrement per high cycle |
| ctrl_i | input | 8 | Auxiliary control byte, bit 6 selects free-running |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| sel_i | input | 2 | Register selection (0..3) |
| wr_data_i | input | 8 | Write data byte |
| rd_data_o | output | 8 | Read data byte for the current selection |
| expire_o | output | 1 | One-cycle expiry pulse to the flag logic |
| flag_clr_o | output | 1 | One-cycle timer-flag clear request |

## Verification
The hardest case to reach is the narrow window around the wrap. It covers the tick that takes the counter to 0xFFFF, the tick after it that reloads, and a counter-high write or mode change landing in the middle of that pair, in one-shot mode as well as free-running. Wraps with a full 16-bit latch would be rare, so the random stimulus mostly writes high bytes of 0 or 1 and small low bytes. This keeps wraps frequent, and loads, mode flips and idle ticks are mixed in at random. Directed runs measure the period with a latch of 3 and count the one-shot pulses over several reload cycles.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;

  typedef enum logic [1:0] {
    SEL_CNT_LO = 2'd0,
    SEL_CNT_HI = 2'd1,
    SEL_LAT_LO = 2'd2,
    SEL_LAT_HI = 2'd3
  } tmr_sel_e;

  typedef struct packed {
    logic lo_wr;    // latch low byte write
    logic hi_wr;    // latch high byte write (either high selection)
    logic cnt_ld;   // copy latch into counter
    logic clr_req;  // timer flag clear request
  } tmr_acc_t;

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import reload_timer_pkg::*;
(
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [1:0] sel_i,
  output tmr_acc_t   acc_o
);

  tmr_sel_e sel;

  always_comb begin
    sel           = tmr_sel_e'(sel_i);
    acc_o         = '0;
    if (wr_i) begin
      unique case (sel)
        SEL_CNT_LO, SEL_LAT_LO: acc_o.lo_wr = 1'b1;
        SEL_CNT_HI: begin
          acc_o.hi_wr   = 1'b1;
          acc_o.cnt_ld  = 1'b1;
          acc_o.clr_req = 1'b1;
        end
        SEL_LAT_HI: begin
          acc_o.hi_wr   = 1'b1;
          acc_o.clr_req = 1'b1;
        end
        default: acc_o = '0;
      endcase
    end
    if (rd_i && (sel == SEL_CNT_LO)) begin
      acc_o.clr_req = 1'b1;
    end
  end

endmodule

// File: rtl/tmr_latch.sv
module tmr_latch #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  localparam int CNT_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_wr_i,
  input  logic              hi_wr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  latch_o,
  output logic [CNT_W-1:0]  load_val_o
);

  logic [CNT_W-1:0] latch_q;
  logic [CNT_W-1:0] latch_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_we;
    assign lane_we = (g == 0) ? lo_wr_i : ((g == LANES - 1) ? hi_wr_i : 1'b0);

    always_comb begin
      latch_d[g*BYTE_W +: BYTE_W] = latch_q[g*BYTE_W +: BYTE_W];
      if (lane_we) begin
        latch_d[g*BYTE_W +: BYTE_W] = wr_data_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
    end else begin
      latch_q <= latch_d;
    end
  end

  assign latch_o    = latch_q;
  assign load_val_o = latch_d;

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cont_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONES = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap_q, wrap_d;
  logic             armed_q, armed_d;
  logic             exp_q, exp_d;

  always_comb begin
    cnt_d   = cnt_q;
    wrap_d  = wrap_q;
    armed_d = armed_q;
    exp_d   = 1'b0;
    if (load_i) begin
      cnt_d   = load_val_i;
      wrap_d  = 1'b0;
      armed_d = 1'b1;
    end else if (tick_i) begin
      if (wrap_q) begin
        cnt_d  = reload_i;
        wrap_d = 1'b0;
      end else if (cnt_q == ZERO) begin
        cnt_d   = ONES;
        wrap_d  = 1'b1;
        exp_d   = cont_i | armed_q;
        armed_d = 1'b0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= ONES;
      wrap_q  <= 1'b0;
      armed_q <= 1'b0;
      exp_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      wrap_q  <= wrap_d;
      armed_q <= armed_d;
      exp_q   <= exp_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = exp_q;

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int CTRL_W   = 8,
  parameter int MODE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              expire_o,
  output logic              flag_clr_o
);

  localparam int LANES = 2;
  localparam int CNT_W = BYTE_W * LANES;

  tmr_acc_t         acc;
  logic [CNT_W-1:0] latch_q;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt_q;
  logic             clr_q, clr_d;

  tmr_decode u_dec (
    .wr_i  (wr_i),
    .rd_i  (rd_i),
    .sel_i (sel_i),
    .acc_o (acc)
  );

  tmr_latch #(.BYTE_W(BYTE_W), .LANES(LANES)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .lo_wr_i    (acc.lo_wr),
    .hi_wr_i    (acc.hi_wr),
    .wr_data_i  (wr_data_i),
    .latch_o    (latch_q),
    .load_val_o (load_val)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_en_i),
    .cont_i     (ctrl_i[MODE_BIT]),
    .load_i     (acc.cnt_ld),
    .load_val_i (load_val),
    .reload_i   (latch_q),
    .cnt_o      (cnt_q),
    .expire_o   (expire_o)
  );

  always_comb begin
    clr_d = acc.clr_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= 1'b0;
    end else begin
      clr_q <= clr_d;
    end
  end

  assign flag_clr_o = clr_q;

  always_comb begin
    unique case (tmr_sel_e'(sel_i))
      SEL_CNT_LO: rd_data_o = cnt_q[BYTE_W-1:0];
      SEL_CNT_HI: rd_data_o = cnt_q[CNT_W-1:BYTE_W];
      SEL_LAT_LO: rd_data_o = latch_q[BYTE_W-1:0];
      SEL_LAT_HI: rd_data_o = latch_q[CNT_W-1:BYTE_W];
      default:    rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [1:0]       sel_i,
  input logic             expire_o,
  input logic             flag_clr_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] latch_q
);

  logic hi_ld;
  assign hi_ld = wr_i && (sel_i == 2'd1);

  assert_load_copies_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hi_ld |=> (cnt_q == latch_q));

  assert_latch_hi_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == 2'd3) |=> flag_clr_o);

  assert_hi_read_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && sel_i == 2'd1 && !wr_i) |=> !flag_clr_o);

  assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en_i && !hi_ld) |=> $stable(cnt_q));

  assert_zero_wraps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en_i && !hi_ld && cnt_q == '0) |=> (cnt_q == '1));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);

endmodule

bind reload_timer reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en_i  (tick_en_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .sel_i      (sel_i),
  .expire_o   (expire_o),
  .flag_clr_o (flag_clr_o),
  .cnt_q      (cnt_q),
  .latch_q    (latch_q)
);

// File: tb/test_reload_timer.sv
`timescale 1ns/1ps
module test_reload_timer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic [7:0] ctrl;
  logic       wr, rd;
  logic [1:0] sel;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       expire, fclr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model state
  logic [15:0] m_latch, m_cnt;
  logic        m_wrap, m_armed, m_exp, m_clr;

  always #2.5 clk = ~clk;

  reload_timer i_reload_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en_i  (tick_en),
    .ctrl_i     (ctrl),
    .wr_i       (wr),
    .rd_i       (rd),
    .sel_i      (sel),
    .wr_data_i  (wdata),
    .rd_data_o  (rdata),
    .expire_o   (expire),
    .flag_clr_o (fclr)
  );

  function automatic logic [7:0] exp_rd(input logic [1:0] s);
    case (s)
      2'd0:    return m_cnt[7:0];
      2'd1:    return m_cnt[15:8];
      2'd2:    return m_latch[7:0];
      default: return m_latch[15:8];
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, expv, $time);
    end
  endtask

  // advance model by one edge using current inputs
  task automatic model_step();
    logic [15:0] old_latch;
    old_latch = m_latch;
    m_clr = (wr && (sel == 2'd1 || sel == 2'd3)) || (rd && sel == 2'd0);
    m_exp = 1'b0;
    if (wr && (sel == 2'd0 || sel == 2'd2)) m_latch[7:0]  = wdata;
    if (wr && (sel == 2'd1 || sel == 2'd3)) m_latch[15:8] = wdata;
    if (wr && sel == 2'd1) begin
      m_cnt = m_latch; m_wrap = 1'b0; m_armed = 1'b1;
    end else if (tick_en) begin
      if (m_wrap) begin
        m_cnt = old_latch; m_wrap = 1'b0;
      end else if (m_cnt == 16'h0) begin
        m_cnt = 16'hFFFF; m_wrap = 1'b1; m_exp = ctrl[6] | m_armed; m_armed = 1'b0;
      end else begin
        m_cnt = m_cnt - 16'd1;
      end
    end
  endtask

  // one cycle: inputs already set; let edge pass, sample on negedge
  task automatic cycle();
    model_step();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    wr = 0; rd = 0; tick_en = 0; wdata = 8'h00;
  endtask

  task automatic write_reg(input logic [1:0] s, input logic [7:0] d);
    idle_inputs(); wr = 1; sel = s; wdata = d;
    cycle();
    idle_inputs();
  endtask

  initial begin
    int seed;
    int gap, last, pulses;
    seed = $urandom(32'h5eed_1234);
    rst_n = 0; ctrl = 8'h00; sel = 0; idle_inputs();
    m_latch = 16'hFFFF; m_cnt = 16'hFFFF; m_wrap = 0; m_armed = 0; m_exp = 0; m_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      sel = s[1:0]; #0.1;
      check("R1 reset read", {8'h0, rdata}, 16'h00FF);
    end
    check("R1 expire low", {15'h0, expire}, 16'h0);
    check("R1 clr low", {15'h0, fclr}, 16'h0);

    // R3: low write leaves counter, R2 read map
    write_reg(2'd0, 8'h03);
    sel = 2'd2; #0.1; check("R3 latch lo", {8'h0, rdata}, 16'h0003);
    sel = 2'd0; #0.1; check("R3 counter kept", {8'h0, rdata}, 16'h00FF);
    sel = 2'd3; #0.1; check("R2 latch hi", {8'h0, rdata}, 16'h00FF);

    // R5: latch-high write clears flag, counter not loaded
    write_reg(2'd3, 8'h00);
    check("R5 clr pulse", {15'h0, fclr}, 16'h1);
    sel = 2'd1; #0.1; check("R5 counter hi kept", {8'h0, rdata}, 16'h00FF);

    // R4 + R9: free-running, latch 3, period 5
    ctrl = 8'h40;
    write_reg(2'd1, 8'h00);
    check("R4 clr pulse", {15'h0, fclr}, 16'h1);
    sel = 2'd0; #0.1; check("R4 counter loaded", {8'h0, rdata}, 16'h0003);
    last = -1; gap = 0; pulses = 0;
    for (int i = 0; i < 22; i++) begin
      tick_en = 1; cycle();
      if (expire) begin
        if (last >= 0) begin
          pulses++;
          check("R8 period latch+2", 16'(i - last), 16'd5);
        end
        last = i;
      end
    end
    check("R9 pulses seen", 16'(pulses), 16'd3);

    // R6: read hi quiet, read lo clears
    idle_inputs(); rd = 1; sel = 2'd1; cycle();
    check("R6 hi read no clr", {15'h0, fclr}, 16'h0);
    rd = 1; sel = 2'd0; cycle();
    check("R6 lo read clr", {15'h0, fclr}, 16'h1);
    idle_inputs();

    // R7: no tick, no change
    sel = 2'd0; #0.1; gap = rdata;
    repeat (5) cycle();
    sel = 2'd0; #0.1; check("R7 hold", {8'h0, rdata}, 16'(gap));

    // R10: one-shot, single pulse over many reloads
    ctrl = 8'h00;
    write_reg(2'd1, 8'h00);
    pulses = 0;
    for (int i = 0; i < 30; i++) begin
      tick_en = 1; cycle();
      if (expire) pulses++;
    end
    check("R10 one-shot once", 16'(pulses), 16'd1);

    // R11: tick and load same edge
    idle_inputs(); wr = 1; sel = 2'd1; wdata = 8'h01; tick_en = 1; cycle();
    idle_inputs(); sel = 2'd0; #0.1;
    check("R11 load wins lo", {8'h0, rdata}, 16'h0003);
    sel = 2'd1; #0.1;
    check("R11 load wins hi", {8'h0, rdata}, 16'h0001);

    // random phase against model, R2 R4 R8 R9 R10 every cycle
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      idle_inputs();
      sel = 2'($urandom_range(0, 3));
      tick_en = ($urandom_range(0, 3) != 0);
      if (r < 12) begin
        wr = 1;
        wdata = (sel[0]) ? 8'($urandom_range(0, 1)) : 8'($urandom_range(0, 6));
      end else if (r < 30) begin
        rd = 1;
      end
      if ($urandom_range(0, 199) == 0) ctrl = ctrl ^ 8'h40;
      cycle();
      check("R9 expire model", {15'h0, expire}, {15'h0, m_exp});
      check("R6 clr model", {15'h0, fclr}, {15'h0, m_clr});
      for (int s = 0; s < 4; s++) begin
        sel = s[1:0]; #0.1;
        check("R2 read model", {8'h0, rdata}, {8'h0, exp_rd(s[1:0])});
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule